// File: doc/BRIEF.md
# Variable-Modulus Cyclic Element Rotator

This block rotates a vector of signed message elements in a circle whose length is set at run time. The physical vector holds `VEC_N` elements of `ELEM_W` bits each, and `VEC_N` is the largest lifting factor the decoder supports. A runtime length `z_len` selects how many of the lowest-indexed elements form the circle. A runtime amount `shift` then moves that circle left, so that output slot `i` takes input slot `(i + shift) mod z_len`. Slots at or above `z_len` are copied straight through.

The block is meant for the message-routing step of a quasi-cyclic LDPC decoder. A decoder that supports several code sizes needs a cyclic shift whose wrap point changes from one block row to the next. The rotator builds two fixed-width logarithmic rotates, one by `shift` and one by `shift - z_len`, and then picks one of them for each element. The logic depth therefore grows with log2 of `VEC_N` and does not grow with the number of supported lengths.

A parameter selects how the result leaves the block. With `REG_OUT = 1`, the result and a valid flag pass through one register stage. With `REG_OUT = 0`, the path is purely combinational.

Top module: `zwrap_rotator`

## Requirements
- R1: For every legal length (2 <= `z_len` <= `VEC_N`) and every legal amount (0 <= `shift` < `z_len`), output element `i` with `i < z_len` equals input element `(i + shift) mod z_len`. Element `i` occupies bits `[i*ELEM_W +: ELEM_W]` of the packed vectors.
- R2: Output elements at indices `z_len` to `VEC_N-1` equal the input elements at the same indices.
- R3: When `shift` is 0, the output vector equals the input vector for any `z_len`.
- R4: With `REG_OUT = 1`, the result for inputs presented with `in_valid = 1` appears one clock later. `out_valid` is `in_valid` delayed by one clock.
- R5: With `REG_OUT = 0`, `dout` follows the inputs in the same cycle, and `out_valid` equals `in_valid`.
- R6: With `REG_OUT = 1`, a synchronous active-high `rst` clears `dout` to all zeros and `out_valid` to 0.
- R7: If `z_len` or `shift` is outside its legal range, the value of `dout` is unspecified, but every bit of it is 0 or 1 (never unknown).
- R8: The boundary lengths behave as R1 describes. `z_len = 2` swaps the first two elements when `shift` is 1. `z_len = VEC_N` gives a plain rotate of the whole vector.
- R9: With `REG_OUT = 1`, a cycle with `in_valid = 0` leaves `dout` unchanged, whatever is on `din`, `z_len` and `shift`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `din`, `z_len` and `shift` |
| din | input | VEC_N*ELEM_W | Input elements; element i at bits [i*ELEM_W +: ELEM_W] |
| z_len | input | $clog2(VEC_N+1) | Runtime circle length |
| shift | input | $clog2(VEC_N) | Left rotate amount inside the circle |
| out_valid | output | 1 | Qualifies `dout` |
| dout | output | VEC_N*ELEM_W | Rotated elements, same layout as `din` |

## Verification
The hardest case to reach is an element that sits exactly where the two candidate rotates meet, that is, where `i + shift` crosses `z_len`. This boundary moves with every pair of length and amount, so a few hand-picked cases leave most crossover points untested. The bench therefore uses an 8-element configuration. For each of several data patterns, it sweeps every legal length together with every legal amount, so that every crossover index is exercised. It then adds ten thousand random legal vectors and a few deliberately illegal length and amount values.

// File: rtl/zrot_pkg.sv
package zrot_pkg;

    // Number of index bits needed to address n elements (at least one).
    function automatic int unsigned idx_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Source slot feeding slot j of a full-width left rotate by step.
    function automatic int unsigned wrap_src(int unsigned j, int unsigned step,
                                             int unsigned n);
        return (j + step) % n;
    endfunction

    // Output stage variants.
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

endpackage

// File: rtl/zrot_barrel.sv
// Full-width logarithmic left rotate: out[j] = in[(j + amt) mod N].
module zrot_barrel
    import zrot_pkg::*;
#(
    parameter int N  = 64,
    parameter int W  = 8,
    parameter int AW = idx_bits(N)
) (
    input  logic [N-1:0][W-1:0] vin,
    input  logic [AW-1:0]       amt,
    output logic [N-1:0][W-1:0] vout
);
    localparam int STAGES = AW;

    logic [N-1:0][W-1:0] stage_v [STAGES+1];

    assign stage_v[0] = vin;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int STEP = (1 << k) % N;
        for (genvar j = 0; j < N; j++) begin : g_slot
            localparam int SRC = wrap_src(j, STEP, N);
            assign stage_v[k+1][j] = amt[k] ? stage_v[k][SRC] : stage_v[k][j];
        end
    end

    assign vout = stage_v[STAGES];
endmodule

// File: rtl/zrot_merge.sv
// Per-element choice between the two rotates, or pass-through above z.
module zrot_merge #(
    parameter int N  = 64,
    parameter int W  = 8,
    parameter int ZW = 7,
    parameter int AW = 6
) (
    input  logic [N-1:0][W-1:0] din,
    input  logic [N-1:0][W-1:0] rot_near,
    input  logic [N-1:0][W-1:0] rot_wrap,
    input  logic [ZW-1:0]       z_len,
    input  logic [AW-1:0]       shift,
    output logic [N-1:0][W-1:0] vout
);
    localparam int SW = ((ZW > AW) ? ZW : AW) + 2;

    for (genvar i = 0; i < N; i++) begin : g_elem
        logic in_circle;
        logic no_wrap;
        assign in_circle = SW'(i) < SW'(z_len);
        assign no_wrap   = (SW'(i) + SW'(shift)) < SW'(z_len);
        assign vout[i]   = !in_circle ? din[i] :
                           (no_wrap ? rot_near[i] : rot_wrap[i]);
    end
endmodule

// File: rtl/zrot_outstage.sv
// Optional one-cycle output register with valid flag.
module zrot_outstage
    import zrot_pkg::*;
#(
    parameter int        N    = 64,
    parameter int        W    = 8,
    parameter out_mode_e MODE = OUT_REG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [N-1:0][W-1:0] vin,
    output logic                out_valid,
    output logic [N-1:0][W-1:0] vout
);
    if (MODE == OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                vout      <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    vout <= vin;
                end
            end
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign vout      = vin;
    end
endmodule

// File: rtl/zwrap_rotator.sv
module zwrap_rotator
    import zrot_pkg::*;
#(
    parameter int VEC_N   = 64,
    parameter int ELEM_W  = 8,
    parameter bit REG_OUT = 1'b1,
    parameter int ZW      = $clog2(VEC_N + 1),
    parameter int RW      = idx_bits(VEC_N)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [VEC_N-1:0][ELEM_W-1:0]  din,
    input  logic [ZW-1:0]                 z_len,
    input  logic [RW-1:0]                 shift,
    output logic                          out_valid,
    output logic [VEC_N-1:0][ELEM_W-1:0]  dout
);
    localparam logic [RW-1:0]  N_MOD = RW'(VEC_N);
    localparam out_mode_e      MODE  = REG_OUT ? OUT_REG : OUT_COMB;

    logic [RW-1:0]                wrap_amt;
    logic [VEC_N-1:0][ELEM_W-1:0] rot_near;
    logic [VEC_N-1:0][ELEM_W-1:0] rot_wrap;
    logic [VEC_N-1:0][ELEM_W-1:0] merged;

    // shift - z_len taken modulo VEC_N; exact for legal inputs because
    // shift + VEC_N - z_len then lies in [0, VEC_N-1].
    assign wrap_amt = shift + N_MOD - RW'(z_len);

    zrot_barrel #(.N(VEC_N), .W(ELEM_W), .AW(RW)) u_near (
        .vin (din),
        .amt (shift),
        .vout(rot_near)
    );

    zrot_barrel #(.N(VEC_N), .W(ELEM_W), .AW(RW)) u_wrap (
        .vin (din),
        .amt (wrap_amt),
        .vout(rot_wrap)
    );

    zrot_merge #(.N(VEC_N), .W(ELEM_W), .ZW(ZW), .AW(RW)) u_merge (
        .din     (din),
        .rot_near(rot_near),
        .rot_wrap(rot_wrap),
        .z_len   (z_len),
        .shift   (shift),
        .vout    (merged)
    );

    zrot_outstage #(.N(VEC_N), .W(ELEM_W), .MODE(MODE)) u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .vin      (merged),
        .out_valid(out_valid),
        .vout     (dout)
    );
endmodule

// File: rtl/zwrap_rotator_chk.sv
module zwrap_rotator_chk #(
    parameter int VEC_N   = 64,
    parameter int ELEM_W  = 8,
    parameter bit REG_OUT = 1'b1,
    parameter int ZW      = 7,
    parameter int RW      = 6
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic [VEC_N-1:0][ELEM_W-1:0]  din,
    input logic [ZW-1:0]                 z_len,
    input logic [RW-1:0]                 shift,
    input logic                          out_valid,
    input logic [VEC_N-1:0][ELEM_W-1:0]  dout
);
    if (REG_OUT) begin : g_reg
        assert_valid_delay_R4: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> out_valid == $past(in_valid));

        assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(dout));

        assert_zero_shift_R3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && shift == '0) |=> dout == $past(din));

        assert_tail_pass_R2: assert property (@(posedge clk) disable iff (rst)
            (in_valid && z_len < VEC_N) |=> dout[VEC_N-1] == $past(din[VEC_N-1]));
    end else begin : g_comb
        assert_valid_same_R5: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid);

        assert_zero_shift_R3: assert property (@(posedge clk) disable iff (rst)
            shift == '0 |-> dout == din);

        assert_tail_pass_R2: assert property (@(posedge clk) disable iff (rst)
            z_len < VEC_N |-> dout[VEC_N-1] == din[VEC_N-1]);

        assert_head_swap_R8: assert property (@(posedge clk) disable iff (rst)
            (z_len == 2 && shift == 1) |-> (dout[0] == din[1] && dout[1] == din[0]));
    end
endmodule

bind zwrap_rotator zwrap_rotator_chk #(
    .VEC_N(VEC_N), .ELEM_W(ELEM_W), .REG_OUT(REG_OUT), .ZW(ZW), .RW(RW)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .din(din), .z_len(z_len),
    .shift(shift), .out_valid(out_valid), .dout(dout)
);

// File: tb/zwrap_rotator_bench.sv
`timescale 1ns/1ps
module zwrap_rotator_bench;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int ZW = $clog2(N + 1);
    localparam int RW = $clog2(N);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [N-1:0][W-1:0] din = '0;
    logic [ZW-1:0]       z_len = ZW'(2);
    logic [RW-1:0]       shift = '0;
    logic                ov_reg, ov_comb;
    logic [N-1:0][W-1:0] dout_reg, dout_comb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    zwrap_rotator #(.VEC_N(N), .ELEM_W(W), .REG_OUT(1'b1)) u_zwrap_rotator (
        .clk(clk), .rst(rst), .in_valid(in_valid), .din(din), .z_len(z_len),
        .shift(shift), .out_valid(ov_reg), .dout(dout_reg)
    );

    zwrap_rotator #(.VEC_N(N), .ELEM_W(W), .REG_OUT(1'b0)) u_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .din(din), .z_len(z_len),
        .shift(shift), .out_valid(ov_comb), .dout(dout_comb)
    );

    function automatic logic [N-1:0][W-1:0] ref_rot(logic [N-1:0][W-1:0] d,
                                                    int z, int r);
        logic [N-1:0][W-1:0] e;
        for (int i = 0; i < N; i++)
            e[i] = (i < z) ? d[(i + r) % z] : d[i];
        return e;
    endfunction

    function automatic logic [N-1:0][W-1:0] head_mask(int z, bit tail);
        logic [N-1:0][W-1:0] m;
        for (int i = 0; i < N; i++)
            m[i] = ((i < z) != tail) ? {W{1'b1}} : {W{1'b0}};
        return m;
    endfunction

    task automatic check(string tag, logic [N*W-1:0] act, logic [N*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one vector, check the comb instance now and the registered one
    // after the next rising edge.
    task automatic apply(logic [N-1:0][W-1:0] d, int z, int r);
        logic [N-1:0][W-1:0] e, mh, mt;
        string tag;
        @(negedge clk);
        din = d; z_len = ZW'(z); shift = RW'(r); in_valid = 1'b1;
        e  = ref_rot(d, z, r);
        mh = head_mask(z, 1'b0);
        mt = head_mask(z, 1'b1);
        tag = (r == 0) ? "R3" : ((z == 2 || z == N) ? "R8" : "R1");
        #1;
        check({tag, " comb"}, dout_comb & mh, e & mh);
        if (z < N) check("R2 comb", dout_comb & mt, e & mt);
        check("R5 comb valid", {{(N*W-1){1'b0}}, ov_comb}, {{(N*W-1){1'b0}}, 1'b1});
        @(negedge clk);
        check({tag, " reg"}, dout_reg & mh, e & mh);
        if (z < N) check("R2 reg", dout_reg & mt, e & mt);
        check("R4 reg valid", {{(N*W-1){1'b0}}, ov_reg}, {{(N*W-1){1'b0}}, 1'b1});
        in_valid = 1'b0;
    endtask

    function automatic logic [N-1:0][W-1:0] pattern(int p);
        logic [N-1:0][W-1:0] d;
        for (int i = 0; i < N; i++)
            d[i] = W'(p * 37 + i * 13 + 1 + ((i & 1) ? 8'h80 : 8'h00));
        return d;
    endfunction

    initial begin : stim
        logic [N-1:0][W-1:0] hold_exp;
        repeat (3) @(negedge clk);
        check("R6 reset dout", dout_reg, '0);
        check("R6 reset valid", {{(N*W-1){1'b0}}, ov_reg}, '0);
        rst = 1'b0;

        // Exhaustive sweep of legal lengths and amounts.
        for (int p = 0; p < 4; p++)
            for (int z = 2; z <= N; z++)
                for (int r = 0; r < z; r++)
                    apply(pattern(p), z, r);

        // R9: idle cycle keeps the registered output.
        apply(pattern(9), 5, 3);
        hold_exp = ref_rot(pattern(9), 5, 3);
        @(negedge clk);
        din = pattern(11); z_len = ZW'(7); shift = RW'(2); in_valid = 1'b0;
        @(negedge clk);
        check("R9 hold dout", dout_reg, hold_exp);
        check("R4 idle valid", {{(N*W-1){1'b0}}, ov_reg}, '0);

        // R7: illegal length / amount keeps outputs known.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            din = pattern(20 + k);
            z_len = (k == 0) ? ZW'(0) : (k == 1) ? ZW'(15) : (k == 2) ? ZW'(3) : ZW'(1);
            shift = (k == 2) ? RW'(6) : RW'(7);
            in_valid = 1'b1;
            #1;
            check("R7 comb known", {{(N*W-1){1'b0}}, ^dout_comb === 1'bx}, '0);
            @(negedge clk);
            check("R7 reg known", {{(N*W-1){1'b0}}, ^dout_reg === 1'bx}, '0);
            in_valid = 1'b0;
        end

        // Random legal vectors.
        for (int n = 0; n < 10000; n++) begin
            logic [N-1:0][W-1:0] d;
            int z, r;
            for (int i = 0; i < N; i++) d[i] = W'($urandom);
            z = 2 + int'($urandom % (N - 1));
            r = int'($urandom % z);
            apply(d, z, r);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule